// File: doc/BRIEF.md
# Preset-Ratio Reference Clock Divider

This block divides an incoming reference clock by one of fifteen fixed ratios and emits one single-cycle pulse per divided period. The pulse is the reference input of a phase/frequency detector in a frequency synthesizer. A 4-bit ratio code selects the ratio. The ratio set is not a plain binary divide value. It has two families: powers of two from 2 to 256, and five times a power of two from 5 to 320. One code value is reserved and selects no ratio.

A single down-counter runs the division. When it reaches zero, it samples the ratio code, reloads, and fires the pulse. A code change made part-way through a period therefore never produces a short or stretched period. Selecting the reserved code stops the pulse train and drops the ratio-valid flag at the next terminal count. The divider stays idle until a legal code returns.

Top module: `ref_ratio_divider`

## Requirements
- R1: While reset is asserted, `div_pulse` and `ratio_ok` are low and the counter is cleared. After reset is released with a legal code, the first pulse appears on the first rising clock edge.
- R2: Codes 0 to 7 divide by 2 to the power (code+1), which gives 2, 4, 8, 16, 32, 64, 128 and 256.
- R3: Codes 9 to 15 divide by 5 times 2 to the power (code-9), which gives 5, 10, 20, 40, 80, 160 and 320.
- R4: Each pulse is exactly one clock cycle wide. Consecutive pulses are exactly N cycles apart, where N is the active ratio.
- R5: `ratio_ok` is high while a legal ratio is active, and `div_pulse` is never high while `ratio_ok` is low.
- R6: Code 8 is reserved. When the counter reaches its terminal count with code 8 applied, no pulse is issued and `ratio_ok` goes low on that edge. Both outputs stay low while code 8 remains applied.
- R7: A code change during a period is ignored until the terminal count. The current period completes at the old ratio, and the new ratio starts with the pulse at that terminal count.
- R8: While idle on the reserved code, applying a legal code yields a pulse and a high `ratio_ok` on the next rising edge.
- R9: The counter never holds a value above 319, the reload for the largest ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | Ratio select code, sampled at each terminal count |
| div_pulse | output | 1 | One-cycle divided reference pulse |
| ratio_ok | output | 1 | High while a legal ratio is running |

## Verification
A wrong reload value or a wrong counter step shows up at the ports as a wrong pulse spacing within one divided period, at most 320 cycles. A code that is sampled at the wrong moment shows up as a shortened period straight after the code change. A faulty reserved-code path shows up as a missing or late drop of `ratio_ok`, or as a pulse on the edge where the terminal count is reached. Sweeping every code and measuring every pulse interval over several periods exposes each of these faults within a few periods.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
    localparam int CODE_W    = 4;
    localparam int CNT_W     = 9;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int RSVD_CODE = 8;

    // Division ratio for a code; 0 marks the reserved code.
    function automatic int ratio_of(input int code);
        if (code < RSVD_CODE)
            return 2 << code;
        else if (code == RSVD_CODE)
            return 0;
        else
            return 5 << (code - RSVD_CODE - 1);
    endfunction

    localparam int MAX_RELOAD = ratio_of(NUM_CODES - 1) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             live;
        logic             pulse;
    } div_state_t;
endpackage

// File: rtl/ref_ratio_lut.sv
module ref_ratio_lut
    import ref_div_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  reload_o,
    output logic              legal_o
);
    logic [CNT_W-1:0]     reload_tbl [NUM_CODES];
    logic [NUM_CODES-1:0] legal_tbl;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
        localparam int RATIO = ratio_of(g);
        if (RATIO > 0) begin : g_legal
            assign reload_tbl[g] = CNT_W'(RATIO - 1);
            assign legal_tbl[g]  = 1'b1;
        end else begin : g_rsvd
            assign reload_tbl[g] = '0;
            assign legal_tbl[g]  = 1'b0;
        end
    end

    assign reload_o = reload_tbl[code_i];
    assign legal_o  = legal_tbl[code_i];
endmodule

// File: rtl/ref_div_core.sv
module ref_div_core
    import ref_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             legal_i,
    output logic             pulse_o,
    output logic             live_o,
    output logic [CNT_W-1:0] cnt_o
);
    div_state_t st_d, st_q;
    logic       at_tc;

    always_comb begin
        st_d  = st_q;
        at_tc = (st_q.cnt == '0);
        if (at_tc) begin
            st_d.pulse = legal_i;
            st_d.live  = legal_i;
            st_d.cnt   = legal_i ? reload_i : '0;
        end else begin
            st_d.pulse = 1'b0;
            st_d.cnt   = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign live_o  = st_q.live;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
    import ref_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              div_pulse,
    output logic              ratio_ok
);
    logic [CNT_W-1:0] reload_val;
    logic             code_legal;
    logic [CNT_W-1:0] cnt_mon;

    ref_ratio_lut u_lut (
        .code_i   (ratio_code),
        .reload_o (reload_val),
        .legal_o  (code_legal)
    );

    ref_div_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload_val),
        .legal_i  (code_legal),
        .pulse_o  (div_pulse),
        .live_o   (ratio_ok),
        .cnt_o    (cnt_mon)
    );
endmodule

// File: rtl/ref_ratio_divider_chk.sv
module ref_ratio_divider_chk
    import ref_div_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_i,
    input logic              pulse_i,
    input logic              ok_i,
    input logic [CNT_W-1:0]  cnt_i
);
    // R1: outputs held low during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!pulse_i && !ok_i && cnt_i == '0)
                else $error("outputs active during reset");
        end
    end

    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_i <= CNT_W'(MAX_RELOAD));

    p_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> !pulse_i);

    p_pulse_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |-> ok_i);

    p_reserved_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0 && code_i == CODE_W'(RSVD_CODE)) |=> (!pulse_i && !ok_i));

    p_mid_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |=> (!pulse_i && $stable(ok_i) && cnt_i == $past(cnt_i) - 1'b1));

    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0 && code_i != CODE_W'(RSVD_CODE)) |=> (pulse_i && ok_i));
endmodule

bind ref_ratio_divider ref_ratio_divider_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (ratio_code),
    .pulse_i (div_pulse),
    .ok_i    (ratio_ok),
    .cnt_i   (cnt_mon)
);

// File: tb/ref_ratio_divider_bench.sv
`timescale 1ns/1ps
module ref_ratio_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd0;
    logic       div_pulse, ratio_ok;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ref_ratio_divider u_ref_ratio_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_code (code),
        .div_pulse  (div_pulse),
        .ratio_ok   (ratio_ok)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Ratio table derived from the requirements
    function automatic int expected_ratio(input int c);
        if (c < 8) return 1 << (c + 1);
        return 5 * (1 << (c - 9));
    endfunction

    // Reset, apply code, release; next posedge is cycle 1
    task automatic start(input logic [3:0] c);
        rst_n = 1'b0;
        code  = c;
        step();
        step();
        check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
        check(ratio_ok == 1'b0, "R1 valid in reset", int'(ratio_ok), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        // R2, R3, R4, R5, R9: sweep every legal code
        for (int c = 0; c < 16; c++) begin
            if (c == 8) continue;
            begin
                int r;
                r = expected_ratio(c);
                start(4'(c));
                for (int n = 1; n <= 3 * r + 2; n++) begin
                    bit exp_p;
                    step();
                    exp_p = ((n - 1) % r) == 0;
                    check(div_pulse == exp_p, (c < 8) ? "R2/R4 pulse" : "R3/R4/R9 pulse",
                          int'(div_pulse), int'(exp_p));
                    check(ratio_ok == 1'b1, "R5 valid", int'(ratio_ok), 1);
                end
            end
        end

        // R6: reserved code from reset
        start(4'd8);
        for (int n = 1; n <= 40; n++) begin
            step();
            check(div_pulse == 1'b0, "R6 pulse", int'(div_pulse), 0);
            check(ratio_ok == 1'b0, "R6 valid", int'(ratio_ok), 0);
        end

        // R7: ratio 8 -> 2 mid-period; pulses at 1, 9, 11, 13, 15
        start(4'd2);
        for (int n = 1; n <= 16; n++) begin
            bit exp_p;
            step();
            exp_p = (n == 1) || (n >= 9 && ((n - 9) % 2) == 0);
            check(div_pulse == exp_p, "R7 pulse", int'(div_pulse), int'(exp_p));
            if (n == 3) code = 4'd0;
        end

        // R6 mid-period stop and R8 resume: ratio 5, reserved after cycle 7, legal after 15
        start(4'd9);
        for (int n = 1; n <= 22; n++) begin
            bit exp_p, exp_v;
            step();
            if (n <= 15) begin
                exp_p = (n == 1) || (n == 6);
                exp_v = (n <= 10);
                check(div_pulse == exp_p, "R6 pulse", int'(div_pulse), int'(exp_p));
                check(ratio_ok == exp_v, "R6 valid", int'(ratio_ok), int'(exp_v));
            end else begin
                exp_p = ((n - 16) % 2) == 0;
                check(div_pulse == exp_p, "R8 pulse", int'(div_pulse), int'(exp_p));
                check(ratio_ok == 1'b1, "R8 valid", int'(ratio_ok), 1);
            end
            if (n == 7)  code = 4'd8;
            if (n == 15) code = 4'd0;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule